// File: doc/BRIEF.md
# Receive Frame Status Trailer

This block closes out an Ethernet receive path. It passes each received frame one byte at a time from an input stream to a valid/ready output stream. Behind the last frame byte it appends four status bytes, so that a consumer further down can read the outcome of the frame together with its data. While the frame streams through, the block counts its bytes, including the four FCS bytes. It also collects the error strobes that the MAC raises along with the bytes: overflow, collision, framing error and FCS error.

When the frame ends, the block captures the count and the error flags. It packs the count and flags into the trailer and decides under a fixed policy whether the frame is accepted or dropped. It also derives the payload length, which is the byte count with the FCS removed. Two 8-bit statistics run alongside the frames and travel in the trailer: runt events reported by the MAC, and frames that saw a collision. Once the downstream side has taken the last trailer byte, a one-cycle done pulse reports the verdict, the length and an input-error flag.

Top module: `rx_status_trailer`

## Requirements
- R1: Every accepted input byte appears on the output unchanged and in order. After the byte marked end-of-frame come exactly four trailer bytes: count bits 7:0, then the status byte, then the runt counter, then the collision counter. No input byte is accepted while the trailer is being sent.
- R2: In the status byte, bit 7 is overflow, bit 6 is collision, bit 5 is framing error and bit 4 is FCS error. Bits 3:0 hold count bits 11:8. Each flag is set when its strobe was high with any byte of the frame.
- R3: The count is the number of frame bytes, FCS included. done_len equals the count minus 4, or 0 when the count is below 4.
- R4: A frame with overflow, framing error or FCS error is reported with done_accept low and done_ierr high.
- R5: A collision flag on its own does not drop a frame and does not set done_ierr. Each frame with the collision flag adds one to an 8-bit collision counter that wraps. The trailer carries the counter value that already includes the current frame.
- R6: A frame without drop flags is accepted only when done_len is greater than 14 and no greater than 1514. Any other length gives done_accept low with done_ierr low.
- R7: The 8-bit runt counter adds one for every cycle in which runt_evt is high and wraps modulo 256. The trailer carries its value as it stands in the cycle the end-of-frame byte is accepted.
- R8: The count saturates at 4095. Any byte received while the count is already 4095 sets the overflow flag.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and out_last stay unchanged. No byte is lost or repeated under backpressure.
- R10: After reset, out_valid and done are low and in_ready is high. done is high for exactly one cycle, the cycle after the handshake of the fourth trailer byte, which is the byte flagged by out_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_oflo | input | 1 | Overflow strobe accompanying the byte |
| in_clsn | input | 1 | Collision strobe accompanying the byte |
| in_fram | input | 1 | Framing error strobe accompanying the byte |
| in_fcs | input | 1 | FCS error strobe accompanying the byte |
| runt_evt | input | 1 | One pulse per runt seen by the MAC |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte (frame data or trailer) |
| out_last | output | 1 | Output byte is the fourth trailer byte |
| done | output | 1 | One-cycle frame completion pulse |
| done_accept | output | 1 | Frame accepted (valid with done) |
| done_ierr | output | 1 | Input error flag seen (valid with done) |
| done_len | output | 12 | Payload length without FCS (valid with done) |

## Verification
Each output byte is due one cycle after its input handshake, because of the single output register. The four trailer bytes follow in the next free output slots, and done comes one cycle after the handshake of the last trailer byte. The bench collects output bytes and done results at the clock edge where the handshake or pulse takes place, so it does not depend on a fixed latency. It checks each frame's bytes and verdict only after that frame's done has been seen, and it also confirms that exactly one done pulse came. Input bytes are offered half a cycle before the edge, and each is treated as taken only when in_ready was high at the edge that follows.

// File: rtl/rxst_pkg.sv
`timescale 1ns/1ps
package rxst_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 12;
  localparam int STAT_W  = 8;
  localparam int TRL_LEN = 4;
  localparam int IDX_W   = $clog2(TRL_LEN);

  // flag vector positions, highest first, as they land in status bits 7:4
  localparam int F_OFLO = 3;
  localparam int F_CLSN = 2;
  localparam int F_FRAM = 1;
  localparam int F_FCS  = 0;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [3:0]        flags_t;
  typedef logic [STAT_W-1:0] stat_t;
  typedef enum logic { ST_DATA, ST_TRAIL } rxst_state_e;

  function automatic cnt_t sat_inc(cnt_t c);
    return (c == '1) ? c : c + cnt_t'(1);
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(flags_t f, cnt_t c);
    return {f, c[CNT_W-1:CNT_W-4]};
  endfunction

  function automatic cnt_t strip_fcs(cnt_t c, int fcs_len);
    return (c >= cnt_t'(fcs_len)) ? c - cnt_t'(fcs_len) : '0;
  endfunction

  function automatic logic size_ok(cnt_t len, int lo, int hi);
    return (int'(len) > lo) && (int'(len) <= hi);
  endfunction

  function automatic logic is_fatal(flags_t f);
    return f[F_OFLO] | f[F_FRAM] | f[F_FCS];
  endfunction
endpackage

// File: rtl/rxst_frame_acc.sv
`timescale 1ns/1ps
module rxst_frame_acc
  import rxst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   byte_acc,
  input  logic   sof,
  input  flags_t stb,
  output cnt_t   cnt_nx,
  output flags_t flags_nx
);
  cnt_t   cnt_q;
  flags_t flags_q;
  logic   cnt_full;

  assign cnt_full = (cnt_q == '1);

  always_comb begin
    if (sof) begin
      cnt_nx   = cnt_t'(1);
      flags_nx = stb;
    end else begin
      cnt_nx   = sat_inc(cnt_q);
      flags_nx = flags_q | stb;
      if (cnt_full) flags_nx[F_OFLO] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flags_q <= '0;
    end else if (byte_acc) begin
      cnt_q   <= cnt_nx;
      flags_q <= flags_nx;
    end
  end

  assert_count_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && !sof && cnt_full) |=> (cnt_q == '1) && flags_q[F_OFLO]);

  assert_sof_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && sof) |=> (cnt_q == cnt_t'(1)));
endmodule

// File: rtl/rxst_stats.sv
`timescale 1ns/1ps
module rxst_stats
  import rxst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  runt_evt,
  input  logic  frame_end,
  input  logic  clsn,
  output stat_t runt_q,
  output stat_t coll_nx
);
  stat_t coll_q;

  assign coll_nx = coll_q + stat_t'(frame_end & clsn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runt_q <= '0;
      coll_q <= '0;
    end else begin
      if (runt_evt)  runt_q <= runt_q + stat_t'(1);
      if (frame_end) coll_q <= coll_nx;
    end
  end

  assert_runt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !runt_evt |=> $stable(runt_q));

  assert_coll_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(coll_q));
endmodule

// File: rtl/rxst_classify.sv
`timescale 1ns/1ps
module rxst_classify
  import rxst_pkg::*;
#(
  parameter int FCS_LEN = 4,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 1514
) (
  input  cnt_t              cnt,
  input  flags_t            flags,
  output cnt_t              len,
  output logic              accept,
  output logic              ierr,
  output logic [BYTE_W-1:0] sts
);
  always_comb begin
    len    = strip_fcs(cnt, FCS_LEN);
    ierr   = is_fatal(flags);
    accept = !ierr && size_ok(len, MIN_LEN, MAX_LEN);
    sts    = status_byte(flags, cnt);
  end
endmodule

// File: rtl/rx_status_trailer.sv
`timescale 1ns/1ps
module rx_status_trailer
  import rxst_pkg::*;
#(
  parameter int FCS_LEN = 4,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 1514
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_oflo,
  input  logic        in_clsn,
  input  logic        in_fram,
  input  logic        in_fcs,
  input  logic        runt_evt,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        done,
  output logic        done_accept,
  output logic        done_ierr,
  output logic [11:0] done_len
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TRL_LEN - 1);

  rxst_state_e       st;
  logic [IDX_W-1:0]  trl_idx;
  cnt_t              snap_cnt;
  flags_t            snap_flags;
  stat_t             snap_runt, snap_coll;

  // named internal events
  logic slot_free, byte_acc, frame_end, trl_load, out_hs, last_hs;
  flags_t stb;
  cnt_t   acc_cnt_nx;
  flags_t acc_flags_nx;
  stat_t  runt_q, coll_nx;
  cnt_t   cls_len;
  logic   cls_accept, cls_ierr;
  logic [BYTE_W-1:0] cls_sts, trl_byte;

  assign stb = {in_oflo, in_clsn, in_fram, in_fcs};

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = (st == ST_DATA) && slot_free;
  assign byte_acc  = in_valid && in_ready;
  assign frame_end = byte_acc && in_eof;
  assign trl_load  = (st == ST_TRAIL) && slot_free;
  assign out_hs    = out_valid && out_ready;
  assign last_hs   = out_hs && out_last;

  rxst_frame_acc u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_acc (byte_acc),
    .sof      (in_sof),
    .stb      (stb),
    .cnt_nx   (acc_cnt_nx),
    .flags_nx (acc_flags_nx)
  );

  rxst_stats u_stats (
    .clk       (clk),
    .rst_n     (rst_n),
    .runt_evt  (runt_evt),
    .frame_end (frame_end),
    .clsn      (acc_flags_nx[F_CLSN]),
    .runt_q    (runt_q),
    .coll_nx   (coll_nx)
  );

  rxst_classify #(
    .FCS_LEN (FCS_LEN),
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
  ) u_cls (
    .cnt    (snap_cnt),
    .flags  (snap_flags),
    .len    (cls_len),
    .accept (cls_accept),
    .ierr   (cls_ierr),
    .sts    (cls_sts)
  );

  // trailer byte order is the contract with the consumer
  always_comb begin
    case (trl_idx)
      IDX_W'(0): trl_byte = snap_cnt[7:0];
      IDX_W'(1): trl_byte = cls_sts;
      IDX_W'(2): trl_byte = snap_runt;
      default:   trl_byte = snap_coll;
    endcase
  end

  // control and snapshot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_DATA;
      trl_idx    <= '0;
      snap_cnt   <= '0;
      snap_flags <= '0;
      snap_runt  <= '0;
      snap_coll  <= '0;
    end else if (frame_end) begin
      st         <= ST_TRAIL;
      trl_idx    <= '0;
      snap_cnt   <= acc_cnt_nx;
      snap_flags <= acc_flags_nx;
      snap_runt  <= runt_q;
      snap_coll  <= coll_nx;
    end else if (trl_load) begin
      trl_idx <= trl_idx + IDX_W'(1);
      if (trl_idx == LAST_IDX) st <= ST_DATA;
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (byte_acc) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_last  <= 1'b0;
    end else if (trl_load) begin
      out_valid <= 1'b1;
      out_data  <= trl_byte;
      out_last  <= (trl_idx == LAST_IDX);
    end else if (out_hs) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  // completion report
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      done_accept <= 1'b0;
      done_ierr   <= 1'b0;
      done_len    <= '0;
    end else begin
      done        <= last_hs;
      done_accept <= last_hs & cls_accept;
      done_ierr   <= last_hs & cls_ierr;
      if (last_hs) done_len <= cls_len;
    end
  end

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && out_last));

  assert_trail_blocks_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TRAIL) |-> !in_ready);

  assert_err_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_ierr) |-> !done_accept);

  assert_len_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_accept) |-> (int'(done_len) > MIN_LEN) && (int'(done_len) <= MAX_LEN));
endmodule

// File: tb/rx_status_trailer_tb.sv
`timescale 1ns/1ps
module rx_status_trailer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic in_oflo = 0, in_clsn = 0, in_fram = 0, in_fcs = 0, runt_evt = 0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last, done, done_accept, done_ierr;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic [11:0] done_len;

  int n_chk = 0, n_bad = 0;
  int runt_model = 0, coll_model = 0;
  int done_cnt = 0;
  logic got_acc, got_ierr;
  logic [11:0] got_len;
  logic [7:0] cap[$];
  bit bp_on = 0;
  logic [15:0] lfsr = 16'hACE1;
  int hold_err = 0;
  logic prev_stall = 0;
  logic [7:0] prev_data = '0;
  logic prev_last = 0;

  always #2 clk = ~clk;

  rx_status_trailer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_oflo(in_oflo),
    .in_clsn(in_clsn), .in_fram(in_fram), .in_fcs(in_fcs), .runt_evt(runt_evt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done(done), .done_accept(done_accept),
    .done_ierr(done_ierr), .done_len(done_len)
  );

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_on ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) cap.push_back(out_data);
      if (done) begin
        done_cnt <= done_cnt + 1;
        got_acc  <= done_accept;
        got_ierr <= done_ierr;
        got_len  <= done_len;
      end
      if (prev_stall && (!out_valid || out_data != prev_data || out_last != prev_last))
        hold_err <= hold_err + 1;
      prev_stall <= out_valid && !out_ready;
      prev_data  <= out_data;
      prev_last  <= out_last;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_runt(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); runt_evt = 1'b1;
      @(negedge clk); runt_evt = 1'b0;
      runt_model = (runt_model + 1) % 256;
    end
  endtask

  // send one frame of n bytes; strobes ride on the last byte
  task automatic send_frame(input int n, input bit f_oflo, input bit f_clsn,
                            input bit f_fram, input bit f_fcs, input string tag);
    int start_done;
    int cnt, len, exp_sts;
    bit oflo_e, acc_e, ierr_e;
    int wait_cyc;
    bit ok;
    start_done = done_cnt;
    cap.delete();
    @(negedge clk); #1;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(i * 7 + n);
      in_sof   = (i == 0);
      in_eof   = (i == n - 1);
      in_oflo  = f_oflo && (i == n - 1);
      in_clsn  = f_clsn && (i == n - 1);
      in_fram  = f_fram && (i == n - 1);
      in_fcs   = f_fcs  && (i == n - 1);
      ok = 0;
      while (!ok) begin
        ok = in_ready;
        @(negedge clk); #1;
      end
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
    in_oflo = 0; in_clsn = 0; in_fram = 0; in_fcs = 0;
    wait_cyc = 0;
    while (done_cnt == start_done && wait_cyc < 20000) begin
      @(negedge clk); wait_cyc++;
    end
    repeat (3) @(negedge clk);
    // expectations from the requirements
    cnt     = (n > 4095) ? 4095 : n;
    oflo_e  = f_oflo || (n > 4095);
    if (f_clsn) coll_model = (coll_model + 1) % 256;
    exp_sts = (int'(oflo_e) << 7) | (int'(f_clsn) << 6) | (int'(f_fram) << 5)
            | (int'(f_fcs) << 4) | (cnt >> 8);
    len     = (cnt >= 4) ? cnt - 4 : 0;
    ierr_e  = oflo_e || f_fram || f_fcs;
    acc_e   = !ierr_e && (len > 14) && (len <= 1514);
    chk(done_cnt == start_done + 1, {"R10 one done pulse ", tag}, done_cnt - start_done, 1);
    chk(cap.size() == n + 4, {"R1 output byte total ", tag}, cap.size(), n + 4);
    if (cap.size() == n + 4) begin
      int bad_i;
      bad_i = -1;
      for (int i = 0; i < n; i++)
        if (cap[i] != 8'(i * 7 + n) && bad_i < 0) bad_i = i;
      chk(bad_i < 0, {"R1 data bytes unchanged ", tag}, bad_i, -1);
      chk(cap[n] == 8'(cnt), {"R3 trailer count low ", tag}, cap[n], cnt & 255);
      chk(cap[n+1] == 8'(exp_sts), {"R2 status byte ", tag}, cap[n+1], exp_sts);
      chk(cap[n+2] == 8'(runt_model), {"R7 runt byte ", tag}, cap[n+2], runt_model);
      chk(cap[n+3] == 8'(coll_model), {"R5 collision byte ", tag}, cap[n+3], coll_model);
    end
    chk(got_len == 12'(len), {"R3 done_len ", tag}, got_len, len);
    chk(got_acc == acc_e, {"R4 R6 done_accept ", tag}, got_acc, acc_e);
    chk(got_ierr == ierr_e, {"R4 done_ierr ", tag}, got_ierr, ierr_e);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 0, "R10 reset out_valid", out_valid, 0);
    chk(done == 0, "R10 reset done", done, 0);
    chk(in_ready == 1, "R10 reset in_ready", in_ready, 1);
  endtask

  task automatic t_errors;
    send_frame(64, 0, 0, 0, 1, "fcs error");
    send_frame(64, 0, 0, 1, 0, "framing error");
    send_frame(64, 1, 0, 0, 0, "overflow strobe");
    send_frame(64, 0, 1, 0, 0, "collision only");
    send_frame(70, 0, 1, 0, 1, "collision plus fcs");
  endtask

  task automatic t_sizes;
    send_frame(3, 0, 0, 0, 0, "shorter than fcs");
    send_frame(18, 0, 0, 0, 0, "payload 14");
    send_frame(19, 0, 0, 0, 0, "payload 15");
    send_frame(1518, 0, 0, 0, 0, "payload 1514");
    send_frame(1519, 0, 0, 0, 0, "payload 1515");
  endtask

  task automatic t_saturate;
    send_frame(4095, 0, 0, 0, 0, "count 4095 exact R8");
    send_frame(4100, 0, 0, 0, 0, "count beyond 4095 R8");
  endtask

  task automatic t_runt;
    pulse_runt(3);
    send_frame(60, 0, 0, 0, 0, "runt three");
    pulse_runt(300);
    send_frame(61, 0, 1, 0, 0, "runt wrap");
  endtask

  task automatic t_backpressure;
    bp_on = 1;
    send_frame(100, 0, 0, 0, 0, "backpressure a R9");
    send_frame(1, 0, 1, 0, 0, "backpressure single byte R9");
    send_frame(33, 0, 0, 1, 0, "backpressure b R9");
    bp_on = 0;
    repeat (4) @(negedge clk);
    chk(hold_err == 0, "R9 output held under stall", hold_err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    send_frame(64, 0, 0, 0, 0, "good 64");
    t_errors();
    t_sizes();
    t_saturate();
    t_runt();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule